// File: doc/BRIEF.md
# Programmable Pixel Clock Post-Divider

This block turns a fast video VCO clock into a pixel-rate clock-enable. The
block runs on the VCO clock itself. It sends out a one-cycle enable pulse once
every N cycles. N is taken from an eight-entry divisor table. The table mixes
the power-of-two ratios 1, 2, 4 and 8 with the odd and composite ratios 3, 5, 6
and 12.

Four video clock channels are available. Software picks one with a 2-bit
select. Each channel keeps a 3-bit divider code in two places: the two low bits
are in a shared post-divide byte, and the high bit is in a shared extension
byte. Both bytes are entries of a small PLL register file. Software reaches that
file through one control word. The control word carries the channel select, a
register index, a data byte and a write flag.

The divider counts only when the video clock control entry marks the VCO as the
active source. When the divisor or the channel changes during operation, the
change is held back until the current period ends. This way no shortened pulse
spacing ever reaches the pixel pipeline.

Top module: `pixclk_postdiv_top`

## Requirements
- R1: Divider codes 0, 1, 2 and 3 give divisors 1, 2, 4 and 8.
- R2: Divider codes 4, 5, 6 and 7 give divisors 3, 5, 6 and 12.
- R3: Every `cfg_wr` loads `cfg_wdata[1:0]` as the channel select (0 to 3), which picks that channel's code.
- R4: Code bits 1:0 for channel n are bits (2n+1):(2n) of PLL register 6, the post-divide byte.
- R5: Code bit 2 for channel n is bit (n+4) of PLL register 11, the extension byte.
- R6: `src_valid` is 1 only while bits 1:0 of PLL register 5 are both 1. While it is 0, `pix_en` stays 0.
- R7: A `cfg_wr` with `cfg_wdata[15]` set stores `cfg_wdata[23:16]` into the PLL register indexed by `cfg_wdata[11:8]`. With bit 15 clear, no register changes. After reset every register holds 0. Index 2 holds the shared reference divider, and indices 7 to 10 hold the per-channel feedback dividers.
- R8: A new divisor or channel takes effect only when a period ends. The pulse interval that is running when the change is made keeps its old length.
- R9: `pix_en` is a single-cycle pulse that repeats every `divisor` cycles while the source is valid. During reset and right after it, `pix_en` is 0 and `src_valid` is 0.
- R10: `divisor` shows the divisor in force. It reads 1 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | VCO clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word: [1:0] channel select, [11:8] PLL index, [15] PLL write flag, [23:16] PLL data |
| pix_en | output | 1 | Pixel clock-enable pulse |
| src_valid | output | 1 | The VCO is the selected video clock source |
| divisor | output | 4 | Divisor in force |

## Verification
A control write is registered on the clock edge that follows the strobe.
`src_valid` follows that register at once, so the bench reads it on the next
falling edge. A new divisor does not take effect until the period in progress
ends, which can take up to 12 cycles. The first pulse after the load comes one
more register stage later. For this reason the bench waits 30 cycles after each
setting before it reads `divisor` or times pulses. It measures the period as the
number of falling edges between two consecutive pulses. The boundary test
counts from a known pulse. That count includes the cycles spent on the write
itself, so the expected interval is the old divisor.

// File: rtl/pcd_pkg.sv
// Package: shared constants and the divisor table for the pixel clock post-divider.
// Assumes divisors fit in DIV_W bits and the register file holds at least 12 entries.
package pcd_pkg;
    localparam int DIV_W    = 4;   // width of a divisor value
    localparam int CODE_W   = 3;   // width of a divider code
    localparam int SEL_W    = 2;   // width of the channel select
    localparam int NUM_CH   = 1 << SEL_W;
    localparam int DATA_W   = 8;   // PLL register width

    // PLL register indices that the datapath decodes
    localparam int IX_REFDIV  = 2;
    localparam int IX_VCTRL   = 5;
    localparam int IX_POST    = 6;
    localparam int IX_FB0     = 7;
    localparam int IX_EXT     = 11;

    // Map a 3-bit code to its integer divisor
    function automatic logic [DIV_W-1:0] code_to_div(input logic [CODE_W-1:0] code);
        case (code)
            3'd0:    code_to_div = 4'd1;
            3'd1:    code_to_div = 4'd2;
            3'd2:    code_to_div = 4'd4;
            3'd3:    code_to_div = 4'd8;
            3'd4:    code_to_div = 4'd3;
            3'd5:    code_to_div = 4'd5;
            3'd6:    code_to_div = 4'd6;
            default: code_to_div = 4'd12;
        endcase
    endfunction
endpackage

// File: rtl/pcd_regfile.sv
// Module: PLL register file, loaded indirectly through one control word.
// Each write updates the channel select. Bit 15 also stores the data byte at the index.
// Assumes the index field starts at bit 8 and AW <= 7.
module pcd_regfile
    import pcd_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [31:0]       wdata,
    output logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] vctrl,
    output logic [DATA_W-1:0] post_reg,
    output logic [DATA_W-1:0] ext_reg
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] regs [DEPTH];
    logic [AW-1:0]     idx;
    logic              unused_bits;

    assign idx         = wdata[8 +: AW];
    assign unused_bits = ^wdata;

    // Store the channel select and any indirect register write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel <= '0;
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (wr) begin
            sel <= wdata[SEL_W-1:0];
            if (wdata[15]) regs[idx] <= wdata[23:16];
        end
    end

    // Present the entries the datapath decodes
    always_comb begin
        vctrl    = regs[IX_VCTRL];
        post_reg = regs[IX_POST];
        ext_reg  = regs[IX_EXT];
    end

    assert_sel_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> sel == $past(wdata[SEL_W-1:0]));
    assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[15] && wdata[8 +: AW] == AW'(IX_POST)) |=> post_reg == $past(wdata[23:16]));
    assert_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(ext_reg));
endmodule

// File: rtl/pcd_index.sv
// Module: builds each channel's 3-bit code from the post-divide and extension
// bytes, picks the selected channel and looks up its divisor. Purely combinational.
module pcd_index
    import pcd_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] post_reg,
    input  logic [DATA_W-1:0] ext_reg,
    output logic [DIV_W-1:0]  req_div
);
    logic [CODE_W-1:0] chan_code [NUM_CH];
    logic [3:0]        unused_ext;

    assign unused_ext = ext_reg[3:0];

    // One code per channel: high bit from the extension byte, low pair from the post byte
    for (genvar n = 0; n < NUM_CH; n++) begin : g_code
        assign chan_code[n] = {ext_reg[n+4], post_reg[2*n +: 2]};
    end

    // Choose the selected channel and convert its code
    always_comb req_div = code_to_div(chan_code[sel]);
endmodule

// File: rtl/pcd_divider.sv
// Module: integer clock-enable divider. It loads a new divisor only at a period
// boundary or while idle. Assumes req_div is a nonzero table value.
module pcd_divider
    import pcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_ok,
    input  logic [DIV_W-1:0] req_div,
    output logic             pix_en,
    output logic [DIV_W-1:0] act_div
);
    logic [DIV_W-1:0] cnt;
    logic             run;
    logic             at_end;

    assign at_end = (cnt == act_div - DIV_W'(1));

    // Count periods, emit the pulse and reload the divisor at boundaries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            run     <= 1'b0;
            pix_en  <= 1'b0;
            act_div <= DIV_W'(1);
        end else if (!src_ok) begin
            cnt     <= '0;
            run     <= 1'b0;
            pix_en  <= 1'b0;
            act_div <= req_div;
        end else if (!run) begin
            cnt     <= '0;
            run     <= 1'b1;
            pix_en  <= 1'b0;
            act_div <= req_div;
        end else if (at_end) begin
            cnt     <= '0;
            pix_en  <= 1'b1;
            act_div <= req_div;
        end else begin
            cnt     <= cnt + DIV_W'(1);
            pix_en  <= 1'b0;
        end
    end

    assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !src_ok |=> !pix_en);
    assert_hold_mid_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && src_ok && !at_end) |=> $stable(act_div));
    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < act_div);
    assert_div_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act_div inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd8, 4'd12});
endmodule

// File: rtl/pixclk_postdiv_top.sv
// Module: top of the pixel clock post-divider. Connects the register file, the
// code assembly and the divider. Everything runs in the VCO clock domain.
module pixclk_postdiv_top
    import pcd_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    output logic        pix_en,
    output logic        src_valid,
    output logic [3:0]  divisor
);
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] vctrl;
    logic [DATA_W-1:0] post_reg;
    logic [DATA_W-1:0] ext_reg;
    logic [DIV_W-1:0]  req_div;
    logic [DIV_W-1:0]  act_div;
    logic [5:0]        unused_vctrl;

    assign unused_vctrl = vctrl[7:2];

    pcd_regfile #(.AW(AW)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .wdata    (cfg_wdata),
        .sel      (sel),
        .vctrl    (vctrl),
        .post_reg (post_reg),
        .ext_reg  (ext_reg)
    );

    pcd_index i_index (
        .sel      (sel),
        .post_reg (post_reg),
        .ext_reg  (ext_reg),
        .req_div  (req_div)
    );

    // The source is valid only when both low control bits are set
    always_comb src_valid = (vctrl[1:0] == 2'b11);

    pcd_divider i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_ok  (src_valid),
        .req_div (req_div),
        .pix_en  (pix_en),
        .act_div (act_div)
    );

    assign divisor = act_div;
endmodule

// File: tb/test_pixclk_postdiv_top.sv
module test_pixclk_postdiv_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        pix_en;
    logic        src_valid;
    logic [3:0]  divisor;

    int checks = 0;
    int errors = 0;
    logic [1:0] cur_sel = 2'd0;

    // R1/R2 expected divisor for each code
    localparam logic [3:0] EXP_DIV [8] = '{4'd1, 4'd2, 4'd4, 4'd8, 4'd3, 4'd5, 4'd6, 4'd12};

    always #5 clk = ~clk;

    pixclk_postdiv_top i_pixclk_postdiv_top (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .pix_en(pix_en), .src_valid(src_valid), .divisor(divisor)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic pll_wr(input logic [3:0] ix, input logic [7:0] d);
        wr({8'h00, d, 1'b1, 3'b000, ix, 6'b0, cur_sel});
    endtask

    task automatic set_sel(input logic [1:0] s);
        cur_sel = s;
        wr({16'h0000, 1'b0, 3'b000, 4'h0, 6'b0, s});
    endtask

    task automatic wait_pulse();
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (pix_en) break;
        end
    endtask

    task automatic measure(output int per);
        per = 0;
        wait_pulse();
        for (int k = 0; k < 100; k++) begin
            @(negedge clk); per++;
            if (pix_en) break;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int per;
        int cnt;
        logic [7:0] post_v, ext_v;
        idle(3);
        // R9/R10 reset state
        check("R9 pix_en in reset", pix_en, 0);
        check("R9 src_valid in reset", src_valid, 0);
        check("R10 divisor in reset", divisor, 1);
        rst_n = 1'b1;
        idle(20);
        check("R9 pix_en after reset with source off", pix_en, 0);

        // R7/R6 enable the source through an indirect write
        pll_wr(4'd5, 8'h03);
        check("R6 R7 src_valid after control write", src_valid, 1);

        // Vector walk: every code on every channel, the other channels hold inverted codes
        for (int ch = 0; ch < 4; ch++) begin
            for (int c = 0; c < 8; c++) begin
                post_v = 8'hFF;
                post_v[2*ch +: 2] = c[1:0];
                ext_v = 8'hF0;
                ext_v[ch+4] = c[2];
                for (int o = 0; o < 4; o++)
                    if (o != ch) begin
                        post_v[2*o +: 2] = ~c[1:0];
                        ext_v[o+4] = ~c[2];
                    end
                pll_wr(4'd6, post_v);
                pll_wr(4'd11, ext_v);
                set_sel(ch[1:0]);
                idle(30);
                // R3 R4 R5 R10 divisor in force; R1/R2 table value
                check($sformatf("R10 R3 R4 R5 divisor ch%0d code%0d", ch, c), divisor, EXP_DIV[c]);
                measure(per);
                check($sformatf("R9 R1 R2 period ch%0d code%0d", ch, c), per, EXP_DIV[c]);
            end
        end

        // R8: change 12 -> 1 mid-period, the running interval keeps length 12
        pll_wr(4'd6, 8'h03);
        pll_wr(4'd11, 8'h10);
        set_sel(2'd0);
        idle(30);
        wait_pulse();
        pll_wr(4'd6, 8'h00);
        pll_wr(4'd11, 8'h00);
        cnt = 4;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk); cnt++;
            if (pix_en) break;
        end
        check("R8 interval at divisor change", cnt, 12);
        measure(per);
        check("R8 new divisor after boundary", per, 1);

        // R7: write with the flag clear changes nothing
        wr({8'h00, 8'h00, 1'b0, 3'b000, 4'd5, 6'b0, 2'd0});
        check("R7 flag-clear write ignored", src_valid, 1);

        // R6: invalid source yields no pulses
        pll_wr(4'd5, 8'h01);
        check("R6 src_valid with partial control", src_valid, 0);
        idle(2);
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (pix_en) cnt++;
        end
        check("R6 pulses while invalid", cnt, 0);
        pll_wr(4'd5, 8'h02);
        idle(2);
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (pix_en) cnt++;
        end
        check("R6 pulses with other bit only", cnt, 0);

        // R9: reset during operation clears everything
        pll_wr(4'd5, 8'h03);
        idle(10);
        rst_n = 1'b0;
        cnt = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (k > 0 && pix_en) cnt++;
        end
        check("R9 pix_en held low in reset", cnt, 0);
        check("R9 src_valid after reset", src_valid, 0);
        check("R10 divisor after reset", divisor, 1);
        rst_n = 1'b1;
        idle(5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule